// File: doc/BRIEF.md
# Six-Channel Interval Timer Bank

The block holds six independent down-counters. Each channel counts pulses from one of four tick-enable inputs, divided by a power-of-two prescaler. It reports each expiry as a sticky status bit, and it raises one interrupt line per channel when that channel's interrupt is unmasked. Software uses a byte-addressed register port with 32-bit data to program the channels. A write needs one clock and a read returns data in the same cycle.

Each channel can run periodically, reloading from its interval after reaching zero. It can also run one-shot, stopping itself when it expires. A reload strobe in the control word copies the interval into the counter. Two spare words at fixed addresses are plain read/write storage with no side effect.

Top module: `tick_timer_bank`

## Requirements
- R1: Output `irq[i]` is high exactly when status bit i (register 0x04) and mask bit i (register 0x00) are both set.
- R2: Writing register 0x04 clears each status bit written as 1 and keeps bits written as 0. An expiry in the same cycle as a clear leaves the bit set.
- R3: Control bits 6:4 hold a value p. The counter takes one step for every 2^p pulses of the selected tick input, counted from the last control write.
- R4: Control bits 3:2 choose which bit of `tick_src` drives the channel. Pulses on the other three inputs have no effect on it.
- R5: Channel i (0..5) sits at 0x10*(i+1). Offset +0 is control, +4 is interval and +8 is the current count. The count is read-only and writes to it are ignored.
- R6: Writing a control word with bit 1 set loads the counter from the interval register. Control reads back its low 8 bits as written.
- R7: Control bit 0 set makes the channel count down. With bit 0 clear the count holds still whatever ticks arrive.
- R8: A step taken from count 1 makes the count 0 and sets the channel's status bit in the same clock. When bit 7 is clear (periodic), the next step reloads the interval.
- R9: When bit 7 is set (one-shot), an expiry also clears control bit 0, so the count stays at 0.
- R10: After reset, mask, status, every control word, every interval and every count read zero and all `irq` outputs are low.
- R11: Reads at undefined offsets return zero and writes there change nothing. Offsets 0x90 and 0x94 read back the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_src | input | 4 | Four tick-enable inputs, one clock wide per pulse |
| irq | output | 6 | Per-channel interrupt lines |

## Verification
A register write becomes visible on `bus_rdata` right after the edge that samples the strobe. A tick pulse sampled at an edge moves the count, the status bit and `irq` at that same edge. Because of this, the bench drives every input at the falling edge and reads one nanosecond later. It waits a whole cycle after the last tick or write before comparing. Expected counts come from a step model in the bench that divides the pulses it issued by 2^p.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int SRC_N  = 4;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = (1 << PRE_W) - 1;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre;
    logic [1:0]       src;
    logic             reload;
    logic             run;
  } ctrl_t;

  function automatic logic [DIV_W-1:0] div_last(input logic [PRE_W-1:0] p);
    logic [DIV_W:0] t;
    t = ((DIV_W+1)'(1) << p) - (DIV_W+1)'(1);
    return t[DIV_W-1:0];
  endfunction

  function automatic logic [3:0] chan_nibble_to_idx(input logic [3:0] nib);
    return nib - 4'd1;
  endfunction
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler
  import tick_timer_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic [SRC_N-1:0]       src_ticks,
  input  logic [1:0]             sel,
  input  logic [PRE_W-1:0]       pre,
  output logic                   fire
);
  logic [DIV_W-1:0] acc;
  logic             hit;
  logic             wrap;

  assign hit  = src_ticks[sel];
  assign wrap = (acc == div_last(pre));
  assign fire = hit && wrap && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (hit)    acc <= wrap ? '0 : acc + 1'b1;
  end

  // an accumulator never passes the terminal value of the current ratio
  p_acc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(pre) && !clear |-> acc <= div_last(pre));
endmodule

// File: rtl/tt_channel.sv
module tt_channel
  import tick_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRC_N-1:0] src_ticks,
  input  logic            ctrl_we,
  input  logic            ival_we,
  input  logic [DW-1:0]   wdata,
  output ctrl_t           ctrl_q,
  output logic [DW-1:0]   ival_q,
  output logic [DW-1:0]   count_q,
  output logic            expire
);
  logic step;
  logic pre_clear;

  function automatic logic [DW-1:0] stepped(input logic [DW-1:0] c,
                                            input logic [DW-1:0] iv,
                                            input logic os);
    if (c == '0) return os ? '0 : iv;
    return c - 1'b1;
  endfunction

  assign pre_clear = ctrl_we || !ctrl_q.run;

  tt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clear(pre_clear), .src_ticks(src_ticks),
    .sel(ctrl_q.src), .pre(ctrl_q.pre), .fire(step)
  );

  assign expire = step && (count_q == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= '0;
    else if (ctrl_we)                  ctrl_q <= ctrl_t'(wdata[7:0]);
    else if (expire && ctrl_q.oneshot) ctrl_q.run <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ival_q <= '0;
    else if (ival_we) ival_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   count_q <= '0;
    else if (ctrl_we && wdata[1]) count_q <= ival_q;
    else if (step)                count_q <= stepped(count_q, ival_q, ctrl_q.oneshot);
  end

  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire && ctrl_q.oneshot && !ctrl_we |=> !ctrl_q.run);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && wdata[1] |=> count_q == $past(ival_q));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run && !ctrl_we |=> $stable(count_q));
  p_expire_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> count_q == '0);
endmodule

// File: rtl/tt_irq.sv
module tt_irq #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mask_we,
  input  logic           stat_we,
  input  logic [NCH-1:0] wdata,
  input  logic [NCH-1:0] expire,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0] clr;

  assign clr = stat_we ? wdata : '0;
  assign irq = stat_q & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata;
      stat_q <= (stat_q & ~clr) | expire;
    end
  end

  p_status_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_q & ~$past(stat_q) & ~$past(expire)) == '0);
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> (stat_q & $past(wdata) & ~$past(expire)) == '0);
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [SRC_N-1:0] tick_src,
  output logic [NCH-1:0] irq
);
  localparam logic [AW-1:0] A_MASK  = AW'('h00);
  localparam logic [AW-1:0] A_STAT  = AW'('h04);
  localparam logic [AW-1:0] A_SPAREA = AW'('h90);
  localparam logic [AW-1:0] A_SPAREB = AW'('h94);
  localparam logic [3:0]    SUB_CTRL = 4'h0;
  localparam logic [3:0]    SUB_IVAL = 4'h4;
  localparam logic [3:0]    SUB_CNT  = 4'h8;

  logic [3:0] nib, sub, idx;
  logic       ch_hit;

  assign nib    = bus_addr[7:4];
  assign sub    = bus_addr[3:0];
  assign idx    = chan_nibble_to_idx(nib);
  assign ch_hit = (nib != 4'd0) && (nib <= 4'(NCH));

  ctrl_t          ctrl_arr [NCH];
  logic [DW-1:0]  ival_arr [NCH];
  logic [DW-1:0]  cnt_arr  [NCH];
  logic [NCH-1:0] expire;
  logic [NCH-1:0] mask_q, stat_q;
  logic [DW-1:0]  spare_a, spare_b;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_i;
    assign sel_i = bus_wr && ch_hit && (idx == 4'(i));
    tt_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n), .src_ticks(tick_src),
      .ctrl_we(sel_i && sub == SUB_CTRL),
      .ival_we(sel_i && sub == SUB_IVAL),
      .wdata(bus_wdata),
      .ctrl_q(ctrl_arr[i]), .ival_q(ival_arr[i]), .count_q(cnt_arr[i]),
      .expire(expire[i])
    );
  end

  tt_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_we(bus_wr && bus_addr == A_MASK),
    .stat_we(bus_wr && bus_addr == A_STAT),
    .wdata(bus_wdata[NCH-1:0]), .expire(expire),
    .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spare_a <= '0;
      spare_b <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_SPAREA) spare_a <= bus_wdata;
      if (bus_addr == A_SPAREB) spare_b <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_MASK)        bus_rdata = DW'(mask_q);
    else if (bus_addr == A_STAT)   bus_rdata = DW'(stat_q);
    else if (bus_addr == A_SPAREA) bus_rdata = spare_a;
    else if (bus_addr == A_SPAREB) bus_rdata = spare_b;
    else if (ch_hit) begin
      for (int i = 0; i < NCH; i++) begin
        if (idx == 4'(i)) begin
          case (sub)
            SUB_CTRL: bus_rdata = DW'(ctrl_arr[i]);
            SUB_IVAL: bus_rdata = ival_arr[i];
            SUB_CNT:  bus_rdata = cnt_arr[i];
            default:  bus_rdata = '0;
          endcase
        end
      end
    end
  end

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rst_n |=> irq == '0 && stat_q == '0);
  p_irq_needs_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == '0 |-> irq == '0);
endmodule

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_src = 0;
  logic [5:0]  irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tick_timer_bank uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_src(tick_src), .irq(irq));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic ticks(input int k, input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk); tick_src = 4'(1 << k);
    end
    @(negedge clk); tick_src = 0;
  endtask

  function automatic logic [7:0] chb(input int ch);
    return 8'((ch + 1) * 16);
  endfunction

  function automatic void model(input int ival, input int p, input int n, input bit os,
                                output int cnt, output bit ex, output bit run);
    int steps = n >> p;
    cnt = ival; ex = 0; run = 1;
    for (int s = 0; s < steps; s++) begin
      if (!run) break;
      if (cnt == 0) cnt = os ? 0 : ival;
      else begin
        cnt--;
        if (cnt == 0) begin ex = 1; if (os) run = 0; end
      end
    end
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int c, p, sr, iv, n, msk;
    bit os, ex, run;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset values
    #1 chk("R10 irq", 32'(irq), 0);
    rd(8'h00, d); chk("R10 mask", d, 0);
    rd(8'h04, d); chk("R10 status", d, 0);
    for (int i = 0; i < 6; i++) begin
      rd(chb(i), d);      chk("R10 ctrl", d, 0);
      rd(chb(i) + 4, d);  chk("R10 ival", d, 0);
      rd(chb(i) + 8, d);  chk("R10 count", d, 0);
    end
    // R5 map, count read-only
    wr(chb(3) + 4, 32'h1234);
    rd(chb(3) + 4, d); chk("R5 ival ch3", d, 32'h1234);
    rd(chb(2) + 4, d); chk("R5 ival ch2 untouched", d, 0);
    wr(chb(3) + 8, 77);
    rd(chb(3) + 8, d); chk("R5 count write ignored", d, 0);
    // R11 undefined and spare
    wr(8'h70, 32'hFFFF_FFFF); rd(8'h70, d); chk("R11 undefined 0x70", d, 0);
    wr(8'h1C, 32'h55); rd(8'h1C, d); chk("R11 undefined 0x1C", d, 0);
    rd(8'h04, d); chk("R11 status untouched", d, 0);
    wr(8'h90, 32'hDEAD_BEEF); wr(8'h94, 32'h0BAD_F00D);
    rd(8'h90, d); chk("R11 spare a", d, 32'hDEAD_BEEF);
    rd(8'h94, d); chk("R11 spare b", d, 32'h0BAD_F00D);
    // R8 periodic on ch0
    wr(chb(0) + 4, 3); wr(chb(0), 32'h03);
    rd(chb(0), d); chk("R6 ctrl readback", d, 32'h03);
    rd(chb(0) + 8, d); chk("R6 reload", d, 3);
    ticks(0, 1); rd(chb(0) + 8, d); chk("R8 one step", d, 2);
    ticks(0, 2); rd(chb(0) + 8, d); chk("R8 reach zero", d, 0);
    rd(8'h04, d); chk("R8 status set", d, 1);
    chk("R1 masked irq", 32'(irq), 0);
    wr(8'h00, 32'h01); #1 chk("R1 unmasked irq", 32'(irq), 1);
    ticks(0, 1); rd(chb(0) + 8, d); chk("R8 periodic reload", d, 3);
    wr(8'h04, 32'h3E); rd(8'h04, d); chk("R2 zero bits keep", d, 1);
    wr(8'h04, 32'h01); rd(8'h04, d); chk("R2 w1c", d, 0);
    #1 chk("R1 irq drops", 32'(irq), 0);
    wr(chb(0), 0);
    // R9 one-shot ch1
    wr(chb(1) + 4, 2); wr(chb(1), 32'h83);
    ticks(0, 2);
    rd(chb(1), d); chk("R9 run cleared", d, 32'h82);
    rd(8'h04, d); chk("R9 status", d, 2);
    ticks(0, 3); rd(chb(1) + 8, d); chk("R9 stays zero", d, 0);
    wr(8'h04, 32'h3F);
    // R7 run bit on ch2
    wr(chb(2) + 4, 5); wr(chb(2), 32'h02);
    ticks(0, 3); rd(chb(2) + 8, d); chk("R7 stopped hold", d, 5);
    wr(chb(2), 32'h01); ticks(0, 2); rd(chb(2) + 8, d); chk("R7 runs", d, 3);
    wr(chb(2), 32'h00); ticks(0, 2); rd(chb(2) + 8, d); chk("R7 stop again", d, 3);
    // R4 source select on ch4 (src 2)
    wr(chb(4) + 4, 10); wr(chb(4), 32'h0B);
    ticks(0, 2); ticks(1, 2); ticks(3, 2);
    rd(chb(4) + 8, d); chk("R4 other sources ignored", d, 10);
    ticks(2, 2); rd(chb(4) + 8, d); chk("R4 selected source", d, 8);
    wr(chb(4), 0);
    // R3 prescaler /8 on ch5
    wr(chb(5) + 4, 10); wr(chb(5), 32'h33);
    ticks(0, 7); rd(chb(5) + 8, d); chk("R3 before 8th", d, 10);
    ticks(0, 1); rd(chb(5) + 8, d); chk("R3 8th pulse", d, 9);
    ticks(0, 16); rd(chb(5) + 8, d); chk("R3 sixteen more", d, 7);
    wr(chb(5), 0);
    // random
    for (int it = 0; it < 40; it++) begin
      c = $urandom_range(0, 5); p = $urandom_range(0, 3); sr = $urandom_range(0, 3);
      iv = $urandom_range(1, 12); os = 1'($urandom_range(0, 1));
      n = $urandom_range(0, iv * (1 << p) * 2); msk = $urandom_range(0, 63);
      wr(8'h04, 32'h3F); wr(8'h00, 32'(msk));
      wr(chb(c) + 4, 32'(iv));
      wr(chb(c), {24'b0, os, 3'(p), 2'(sr), 2'b11});
      wr(8'h04, 32'h3F & ~(32'd1 << c));
      ticks(sr, n);
      model(iv, p, n, os, iv, ex, run);
      rd(chb(c) + 8, d); chk("R3 R8 random count", d, 32'(iv));
      rd(8'h04, d); chk("R8 random status", 32'(d[c]), 32'(ex));
      rd(chb(c), d); chk("R9 random run", 32'(d[0]), 32'(run));
      #1 chk("R1 random irq", 32'(irq[c]), 32'(ex & msk[c]));
      wr(chb(c), 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule